// File: doc/BRIEF.md
# Wake-up and Boot Delay Sequencer

This block keeps the core held after it leaves a suspend state or after a low-voltage reset, and releases it only when a hold time has run out. The length of the hold and the clock it is counted on depend on the cause of the hold. A plain wake-up counts ticks of the slow internal RC oscillator. A fast wake-up counts system clock cycles. When the core slept with its clocks stopped, a fast wake-up first waits for the oscillator to report that it is stable. A low-voltage reset counts RC ticks, using a long or a short recovery length.

All logic runs on one system clock. RC ticks arrive as one-cycle enable pulses. The oscillator itself is outside the block and is seen only through the tick and stable inputs. The core asks to suspend with `sleep_i`. While the block holds for a fast wake-up, `clk_sel_o` tells the clock logic to time the hold on the system clock.

Top module: `wake_boot_seq`

## Requirements
- R1: After reset, `run_o` and `clk_sel_o` are 0 and stay 0 until a wake or low-voltage event is taken.
- R2: A plain wake-up (`fast_wake_i`=0) releases the core at the clock edge that takes the NORM_WAKE_TICKS-th RC tick after the edge that took `wake_i`. A tick sampled at the same edge as the event is not counted, and cycles without a tick do not advance the hold.
- R3: A fast wake-up from the clock-kept suspend (`susp_stop_i`=0) releases the core at the FAST_WAKE_CYCLES-th clock edge after the edge that took `wake_i`.
- R4: A fast wake-up from the clocks-stopped suspend (`susp_stop_i`=1) holds the core while `osc_ok_i` is 0. The edge that first samples `osc_ok_i`=1 starts the count, and the core is released FAST_WAKE_CYCLES edges after that edge.
- R5: While `ext_osc_i`=1, a wake-up is always timed as a plain wake-up (R2), whatever the value of `fast_wake_i`, and `clk_sel_o` stays 0.
- R6: A low-voltage event with `fast_lvr_i`=0 releases the core at the edge that takes the NORM_LVR_TICKS-th RC tick after the event edge.
- R7: A low-voltage event with `fast_lvr_i`=1 releases the core at the edge that takes the FAST_LVR_TICKS-th RC tick after the event edge.
- R8: `clk_sel_o` is 1 exactly while a fast-wake hold is in progress (waiting for the oscillator or counting). It is 0 while `run_o` is 1.
- R9: A wake or low-voltage event taken during a hold discards the hold in progress and restarts the count from zero, with the timing of the new event.
- R10: A low-voltage event wins over a wake event at the same edge. A low-voltage event taken while the core runs drops `run_o` after that edge. A wake event taken while the core runs is ignored.
- R11: `sleep_i` taken while the core runs drops `run_o` after that edge. `sleep_i` during a hold has no effect on the hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rc_tick_i | input | 1 | One-cycle pulse for each slow RC oscillator tick |
| susp_stop_i | input | 1 | Suspend type: 1 means clocks stopped, 0 means oscillator kept running |
| sleep_i | input | 1 | Core request to enter suspend |
| wake_i | input | 1 | Wake event pulse |
| lvr_i | input | 1 | Low-voltage reset event pulse |
| osc_ok_i | input | 1 | Oscillator stable indication |
| fast_wake_i | input | 1 | Fast wake-up selected |
| fast_lvr_i | input | 1 | Short recovery after low-voltage reset selected |
| ext_osc_i | input | 1 | External oscillator enabled (forces a plain wake-up) |
| run_o | output | 1 | Core released and running |
| clk_sel_o | output | 1 | Hold is timed on the system clock |

## Verification
The state and the hold configuration are registered, so a wrong state shows at `run_o` and `clk_sel_o` after the next edge. A hold counted on the wrong clock, a length taken from the wrong source, or a count that fails to restart shows up as a release edge that is off by whole ticks or cycles. For that reason each release is compared against a cycle number computed in advance. A hold that never ends, or a release that was not expected, is caught directly.

// File: rtl/wbs_pkg.sv
package wbs_pkg;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_WAIT_OSC = 2'd1,
      ST_COUNT    = 2'd2,
      ST_RUN      = 2'd3
   } wbs_state_e;

   typedef enum logic [1:0] {
      LEN_WAKE_NORM = 2'd0,
      LEN_WAKE_FAST = 2'd1,
      LEN_LVR_NORM  = 2'd2,
      LEN_LVR_FAST  = 2'd3
   } wbs_len_e;

   typedef struct packed {
      logic     use_sys;
      logic     need_osc;
      wbs_len_e len_sel;
   } wbs_cfg_t;

endpackage

// File: rtl/wbs_mode_dec.sv
module wbs_mode_dec
   import wbs_pkg::*;
(
   input  logic     wake_i,
   input  logic     lvr_i,
   input  logic     in_run_i,
   input  logic     susp_stop_i,
   input  logic     fast_wake_i,
   input  logic     fast_lvr_i,
   input  logic     ext_osc_i,
   output logic     start_o,
   output wbs_cfg_t cfg_o
);

   logic fast_ok;

   assign fast_ok = fast_wake_i && !ext_osc_i;

   always_comb begin
      start_o = lvr_i || (wake_i && !in_run_i);
      cfg_o   = '0;
      if (lvr_i) begin
         cfg_o.use_sys  = 1'b0;
         cfg_o.need_osc = 1'b0;
         cfg_o.len_sel  = fast_lvr_i ? LEN_LVR_FAST : LEN_LVR_NORM;
      end else if (fast_ok) begin
         cfg_o.use_sys  = 1'b1;
         cfg_o.need_osc = susp_stop_i;
         cfg_o.len_sel  = LEN_WAKE_FAST;
      end else begin
         cfg_o.use_sys  = 1'b0;
         cfg_o.need_osc = 1'b0;
         cfg_o.len_sel  = LEN_WAKE_NORM;
      end
   end

endmodule

// File: rtl/wbs_hold_cnt.sv
module wbs_hold_cnt
   import wbs_pkg::*;
#(
   parameter int NORM_WAKE_TICKS  = 1024,
   parameter int FAST_WAKE_CYCLES = 128,
   parameter int NORM_LVR_TICKS   = 1024,
   parameter int FAST_LVR_TICKS   = 64,
   parameter int CNT_W            = 10
)(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     clr_i,
   input  logic     en_i,
   input  wbs_len_e len_sel_i,
   output logic     done_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_val;

   always_comb begin
      unique case (len_sel_i)
         LEN_WAKE_NORM: last_val = CNT_W'(NORM_WAKE_TICKS - 1);
         LEN_WAKE_FAST: last_val = CNT_W'(FAST_WAKE_CYCLES - 1);
         LEN_LVR_NORM:  last_val = CNT_W'(NORM_LVR_TICKS - 1);
         default:       last_val = CNT_W'(FAST_LVR_TICKS - 1);
      endcase
   end

   assign done_o = en_i && (cnt_q == last_val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (en_i && !done_o) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wbs_fsm.sv
module wbs_fsm
   import wbs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  wbs_cfg_t   cfg_i,
   input  logic       sleep_i,
   input  logic       osc_ok_i,
   input  logic       done_i,
   output wbs_state_e state_o,
   output wbs_cfg_t   cfg_q_o,
   output logic       clr_o
);

   wbs_state_e state_q, state_d;
   wbs_cfg_t   cfg_q, cfg_d;

   always_comb begin
      state_d = state_q;
      cfg_d   = cfg_q;
      clr_o   = 1'b0;
      if (start_i) begin
         cfg_d   = cfg_i;
         clr_o   = 1'b1;
         state_d = cfg_i.need_osc ? ST_WAIT_OSC : ST_COUNT;
      end else begin
         unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_WAIT_OSC: begin
               if (osc_ok_i) begin
                  state_d = ST_COUNT;
                  clr_o   = 1'b1;
               end
            end
            ST_COUNT: begin
               if (done_i) state_d = ST_RUN;
            end
            default: begin
               if (sleep_i) state_d = ST_IDLE;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cfg_q   <= '0;
      end else begin
         state_q <= state_d;
         cfg_q   <= cfg_d;
      end
   end

   assign state_o = state_q;
   assign cfg_q_o = cfg_q;

endmodule

// File: rtl/wake_boot_seq.sv
module wake_boot_seq
   import wbs_pkg::*;
#(
   parameter int NORM_WAKE_TICKS  = 1024,
   parameter int FAST_WAKE_CYCLES = 128,
   parameter int NORM_LVR_TICKS   = 1024,
   parameter int FAST_LVR_TICKS   = 64
)(
   input  logic clk,
   input  logic rst_n,
   input  logic rc_tick_i,
   input  logic susp_stop_i,
   input  logic sleep_i,
   input  logic wake_i,
   input  logic lvr_i,
   input  logic osc_ok_i,
   input  logic fast_wake_i,
   input  logic fast_lvr_i,
   input  logic ext_osc_i,
   output logic run_o,
   output logic clk_sel_o
);

   localparam int MAX_WAKE = (NORM_WAKE_TICKS > FAST_WAKE_CYCLES) ? NORM_WAKE_TICKS : FAST_WAKE_CYCLES;
   localparam int MAX_LVR  = (NORM_LVR_TICKS > FAST_LVR_TICKS) ? NORM_LVR_TICKS : FAST_LVR_TICKS;
   localparam int MAX_LEN  = (MAX_WAKE > MAX_LVR) ? MAX_WAKE : MAX_LVR;
   localparam int CNT_W    = $clog2(MAX_LEN);

   generate
      if (NORM_WAKE_TICKS < 2) begin : g_bad_nw
         $error("NORM_WAKE_TICKS must be at least 2");
      end
      if (FAST_WAKE_CYCLES < 2) begin : g_bad_fw
         $error("FAST_WAKE_CYCLES must be at least 2");
      end
      if (NORM_LVR_TICKS < 2) begin : g_bad_nl
         $error("NORM_LVR_TICKS must be at least 2");
      end
      if (FAST_LVR_TICKS < 2) begin : g_bad_fl
         $error("FAST_LVR_TICKS must be at least 2");
      end
   endgenerate

   wbs_state_e state;
   wbs_cfg_t   cfg_new, cfg_q;
   logic       start, clr, done, cnt_en, in_run;

   assign in_run = (state == ST_RUN);
   assign cnt_en = (state == ST_COUNT) && (cfg_q.use_sys || rc_tick_i);

   wbs_mode_dec u_dec (
      .wake_i      (wake_i),
      .lvr_i       (lvr_i),
      .in_run_i    (in_run),
      .susp_stop_i (susp_stop_i),
      .fast_wake_i (fast_wake_i),
      .fast_lvr_i  (fast_lvr_i),
      .ext_osc_i   (ext_osc_i),
      .start_o     (start),
      .cfg_o       (cfg_new)
   );

   wbs_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .cfg_i    (cfg_new),
      .sleep_i  (sleep_i),
      .osc_ok_i (osc_ok_i),
      .done_i   (done),
      .state_o  (state),
      .cfg_q_o  (cfg_q),
      .clr_o    (clr)
   );

   wbs_hold_cnt #(
      .NORM_WAKE_TICKS  (NORM_WAKE_TICKS),
      .FAST_WAKE_CYCLES (FAST_WAKE_CYCLES),
      .NORM_LVR_TICKS   (NORM_LVR_TICKS),
      .FAST_LVR_TICKS   (FAST_LVR_TICKS),
      .CNT_W            (CNT_W)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (clr),
      .en_i      (cnt_en),
      .len_sel_i (cfg_q.len_sel),
      .done_o    (done)
   );

   assign run_o     = in_run;
   assign clk_sel_o = cfg_q.use_sys && ((state == ST_WAIT_OSC) || (state == ST_COUNT));

endmodule

// File: rtl/wake_boot_seq_chk.sv
module wake_boot_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic sleep_i,
   input logic wake_i,
   input logic lvr_i,
   input logic ext_osc_i,
   input logic run_o,
   input logic clk_sel_o
);

   // R8
   run_excl_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |-> !clk_sel_o);

   // R11
   sleep_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && sleep_i) |=> !run_o);

   // R10
   lvr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvr_i |=> !run_o);

   // R10
   wake_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o && wake_i && !lvr_i && !sleep_i) |=> run_o);

   // R5
   ext_osc_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_o && wake_i && ext_osc_i) |=> !clk_sel_o);

   // R9
   no_rise_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> !$past(wake_i || lvr_i));

endmodule

bind wake_boot_seq wake_boot_seq_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .sleep_i   (sleep_i),
   .wake_i    (wake_i),
   .lvr_i     (lvr_i),
   .ext_osc_i (ext_osc_i),
   .run_o     (run_o),
   .clk_sel_o (clk_sel_o)
);

// File: tb/wake_boot_seq_tb.sv
module wake_boot_seq_tb;

   localparam int NW = 1024;
   localparam int FW = 128;
   localparam int NL = 1024;
   localparam int FL = 64;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rc_tick_i = 1'b0;
   logic susp_stop_i = 1'b0;
   logic sleep_i = 1'b0;
   logic wake_i = 1'b0;
   logic lvr_i = 1'b0;
   logic osc_ok_i = 1'b1;
   logic fast_wake_i = 1'b0;
   logic fast_lvr_i = 1'b0;
   logic ext_osc_i = 1'b0;
   logic run_o, clk_sel_o;

   int cyc = 0;
   int n_chk = 0;
   int n_err = 0;
   int exp_q[$];
   string tag_q[$];
   logic run_prev = 1'b0;
   int got_exp;
   string got_tag;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   // RC tick lands on every edge whose number is a multiple of 4
   always @(negedge clk) rc_tick_i = ((cyc + 1) % 4 == 0);

   wake_boot_seq u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .rc_tick_i   (rc_tick_i),
      .susp_stop_i (susp_stop_i),
      .sleep_i     (sleep_i),
      .wake_i      (wake_i),
      .lvr_i       (lvr_i),
      .osc_ok_i    (osc_ok_i),
      .fast_wake_i (fast_wake_i),
      .fast_lvr_i  (fast_lvr_i),
      .ext_osc_i   (ext_osc_i),
      .run_o       (run_o),
      .clk_sel_o   (clk_sel_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   function automatic int tick_edge(input int e, input int n);
      return ((e / 4) + 1) * 4 + 4 * (n - 1);
   endfunction

   task automatic push_exp(input int edge_no, input string req);
      exp_q.push_back(edge_no);
      tag_q.push_back(req);
   endtask

   // monitor: every rising run_o must match the next expected release edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (run_o && !run_prev) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "unexpected release", cyc, -1);
            end else begin
               got_exp = exp_q.pop_front();
               got_tag = tag_q.pop_front();
               chk(cyc == got_exp, got_tag, cyc, got_exp);
            end
         end
      end
      run_prev = run_o;
   end

   task automatic ev(input bit w, input bit l, input bit s, output int e);
      @(negedge clk);
      wake_i = w; lvr_i = l; sleep_i = s;
      e = cyc + 1;
      @(negedge clk);
      wake_i = 1'b0; lvr_i = 1'b0; sleep_i = 1'b0;
   endtask

   task automatic wait_run(input string req, input int lim);
      int k = 0;
      while (!run_o && k < lim) begin
         @(negedge clk);
         k++;
      end
      chk(run_o == 1'b1, req, int'(run_o), 1);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   initial begin
      #(4 * 150000);
      if (!done_flag) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         summary();
         $finish;
      end
   end

   initial begin
      int e, e2, c, seen;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(run_o == 1'b0, "R1 run after reset", int'(run_o), 0);
      chk(clk_sel_o == 1'b0, "R1 sel after reset", int'(clk_sel_o), 0);
      seen = 0;
      repeat (20) begin
         @(negedge clk);
         if (run_o || clk_sel_o) seen++;
      end
      chk(seen == 0, "R1 held without event", seen, 0);

      // plain wake-up counted on RC ticks
      ev(1, 0, 0, e);
      push_exp(tick_edge(e, NW), "R2 plain wake release");
      repeat (10) @(negedge clk);
      chk(clk_sel_o == 1'b0, "R2 sel during plain hold", int'(clk_sel_o), 0);
      wait_run("R2 released", 6000);

      // sleep drops run
      ev(0, 0, 1, e);
      chk(run_o == 1'b0, "R11 sleep drops run", int'(run_o), 1'b0);

      // fast wake, clock kept
      fast_wake_i = 1'b1; susp_stop_i = 1'b0;
      ev(1, 0, 0, e);
      push_exp(e + FW, "R3 fast wake release");
      repeat (5) @(negedge clk);
      chk(clk_sel_o == 1'b1, "R8 sel during fast hold", int'(clk_sel_o), 1);
      wait_run("R3 released", 1000);
      chk(clk_sel_o == 1'b0, "R8 sel low in run", int'(clk_sel_o), 0);

      // fast wake, clocks stopped, oscillator late
      ev(0, 0, 1, e);
      susp_stop_i = 1'b1; osc_ok_i = 1'b0;
      ev(1, 0, 0, e);
      repeat (50) @(negedge clk);
      chk(run_o == 1'b0, "R4 held until osc ok", int'(run_o), 0);
      chk(clk_sel_o == 1'b1, "R8 sel while waiting osc", int'(clk_sel_o), 1);
      @(negedge clk);
      osc_ok_i = 1'b1;
      c = cyc;
      push_exp(c + 1 + FW, "R4 stopped-clock fast release");
      wait_run("R4 released", 1000);

      // external oscillator forces plain wake
      ev(0, 0, 1, e);
      ext_osc_i = 1'b1;
      ev(1, 0, 0, e);
      push_exp(tick_edge(e, NW), "R5 ext osc plain timing");
      repeat (3) @(negedge clk);
      chk(clk_sel_o == 1'b0, "R5 sel low with ext osc", int'(clk_sel_o), 0);
      wait_run("R5 released", 6000);
      ext_osc_i = 1'b0;

      // low-voltage event while running, long recovery
      fast_lvr_i = 1'b0;
      ev(0, 1, 0, e);
      chk(run_o == 1'b0, "R10 lvr drops run", int'(run_o), 0);
      push_exp(tick_edge(e, NL), "R6 long lvr release");
      wait_run("R6 released", 6000);

      // short recovery
      fast_lvr_i = 1'b1;
      ev(0, 1, 0, e);
      push_exp(tick_edge(e, FL), "R7 short lvr release");
      wait_run("R7 released", 1000);

      // restart during hold
      ev(0, 0, 1, e);
      fast_wake_i = 1'b0; susp_stop_i = 1'b0;
      ev(1, 0, 0, e);
      repeat (100) @(negedge clk);
      fast_wake_i = 1'b1;
      ev(1, 0, 0, e2);
      push_exp(e2 + FW, "R9 restart uses new event");
      wait_run("R9 released", 1000);

      // simultaneous wake and lvr
      ev(0, 0, 1, e);
      fast_wake_i = 1'b1; fast_lvr_i = 1'b1;
      ev(1, 1, 0, e);
      push_exp(tick_edge(e, FL), "R10 lvr wins over wake");
      @(negedge clk);
      chk(clk_sel_o == 1'b0, "R10 lvr timing on RC", int'(clk_sel_o), 0);
      wait_run("R10 released", 1000);

      // wake while running ignored
      ev(1, 0, 0, e);
      seen = 0;
      repeat (200) begin
         @(negedge clk);
         if (!run_o || clk_sel_o) seen++;
      end
      chk(seen == 0, "R10 wake in run ignored", seen, 0);

      // sleep during hold ignored
      ev(0, 0, 1, e);
      susp_stop_i = 1'b0;
      ev(1, 0, 0, e);
      push_exp(e + FW, "R11 sleep in hold ignored");
      repeat (20) @(negedge clk);
      ev(0, 0, 1, e2);
      wait_run("R11 released", 1000);

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "pending releases", exp_q.size(), 0);
      done_flag = 1'b1;
      summary();
      $finish;
   end

endmodule